// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one frame on the single-wire, open-drain consumer electronics control bus. A host loads a small entry buffer over a plain write port. Each entry holds one byte block: the data byte, the end-of-message flag and the value to send in the acknowledge slot. The host then gives a launch pulse together with the total bit count, a retry budget and a choice of bus free time. The block first waits until the line has been high for the selected number of nominal bit periods. It then drives the start bit and sends every block as eight data bits (MSB first), the end-of-message bit and the acknowledge slot.

All bit timing is counted in a base tick, which a prescaler derives from the clock. With the default constants one tick is 50 us. The line is modelled as a drive-low enable plus a raw input that the block synchronises itself. The block checks the acknowledge slot and watches for a competing initiator. A failed attempt is retried after a short free time. Completion is reported on three mutually exclusive flags.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `drive_low_o` is 0, `busy_o` is 0, and all three result flags are 0 until the first completion.
- R2: A `start_i` pulse while idle latches `bit_count_i`, `retry_max_i` and `free_sel_i`, clears the result flags and raises `busy_o` on the next clock. `busy_o` stays high until completion. A `start_i` pulse while busy is ignored: the bits on the line and the attempt count stay those of the running frame.
- R3: Before the first attempt, the synchronised line must be seen high for N*BIT_PER consecutive ticks. N is `free_short_i` for `free_sel_i`=0, `free_mid_i` for 1, and `free_long_i` for 2 or 3. Any low level restarts the count.
- R4: The start bit drives the line low for START_LOW ticks (3.7 ms) within a START_PER tick period (4.5 ms).
- R5: A logic 0 bit is driven low for ZERO_LOW ticks (1.5 ms), a logic 1 bit for ONE_LOW ticks (0.6 ms). Every non-start bit lasts BIT_PER ticks (2.4 ms).
- R6: Entries are sent in index order from 0. Each 12-bit entry sends bits 11 down to 4 (the data byte, MSB first), then bit 1 (end of message), then bit 0 (acknowledge slot value); bits 3:2 are not sent. An attempt ends after `bit_count_i` bits including the start bit, i.e. 10 times the block count plus 1.
- R7: When entry bit 0 is 1, the block releases the line in the acknowledge slot and samples it ACK_SAMPLE ticks (1.05 ms) after the slot's falling edge. Low means acknowledged; high means no acknowledge and ends the attempt at once. When entry bit 0 is 0, the slot is driven as a logic 0 and is not sampled.
- R8: During a logic 1 data or end-of-message bit, a low line in ticks ONE_LOW+1 to ZERO_LOW-1 of the bit is a lost arbitration. The block then stops driving from the next clock on.
- R9: A failed attempt (lost arbitration or no acknowledge) is repeated up to `retry_max_i` more times. Each repeat waits `free_short_i` bit periods of idle line.
- R10: Completion sets exactly one of `done_ok_o`, `arb_lost_o` or `no_ack_o`, chosen by the outcome of the last attempt, in the same clock in which `busy_o` falls. The flag holds until the next accepted launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry buffer write strobe |
| wr_idx_i | input | $clog2(DEPTH) | Entry index to write |
| wr_entry_i | input | 12 | Entry: byte in 11:4, end-of-message in 1, acknowledge slot value in 0 |
| bit_count_i | input | CNT_W | Total bits of the frame including the start bit |
| retry_max_i | input | 3 | Number of automatic repeats after a failed attempt |
| free_sel_i | input | 2 | Free time choice: 0 short, 1 mid, 2/3 long |
| free_short_i | input | 4 | Short free time in bit periods, also used for repeats |
| free_mid_i | input | 4 | Mid free time in bit periods |
| free_long_i | input | 4 | Long free time in bit periods |
| start_i | input | 1 | Launch pulse |
| line_i | input | 1 | Raw bus line level |
| drive_low_o | output | 1 | Open-drain pull-down enable |
| busy_o | output | 1 | Frame in progress |
| done_ok_o | output | 1 | Last frame sent and acknowledged |
| arb_lost_o | output | 1 | Last frame ended on lost arbitration |
| no_ack_o | output | 1 | Last frame ended without acknowledge |

## Verification
Random frames of one to three blocks with random bytes and random free-time choices show that bit ordering, pulse widths, periods and the idle wait are correct for any content and any of the three free counts. Directed frames cover the remaining behaviour. One leaves every acknowledge unanswered, which separates the retry budget and the short repeat wait from the first-attempt wait. One sends an acknowledge slot as logic 0 with no follower, to show that slot is not sampled. Others pull the line low during a logic 1 bit with and without a retry budget, which separates lost arbitration from no acknowledge. The last two hold the line low at launch and pulse `start_i` mid-frame; these show the idle count restarting and a busy launch having no effect.

// File: rtl/cec_frame_tx_pkg.sv
package cec_frame_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} tx_state_e;

  localparam int ENTRY_W = 12;

  // bit order within one block: byte MSB..LSB, eom, ack slot
  function automatic logic entry_bit(input logic [ENTRY_W-1:0] e, input logic [3:0] pos);
    logic b;
    case (pos)
      4'd0: b = e[11];
      4'd1: b = e[10];
      4'd2: b = e[9];
      4'd3: b = e[8];
      4'd4: b = e[7];
      4'd5: b = e[6];
      4'd6: b = e[5];
      4'd7: b = e[4];
      4'd8: b = e[1];
      default: b = e[0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int TICK_DIV = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = $clog2(TICK_DIV + 1);
  logic [DW-1:0] cnt;

  assign tick_o = (cnt == DW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (tick_o) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq <= '1;  // idle bus reads high
    else sq <= {sq[STAGES-2:0], line_i};
  end

  assign line_o = sq[STAGES-1];
endmodule

// File: rtl/cec_tx_buf.sv
module cec_tx_buf #(
  parameter int DEPTH = 16,
  parameter int EW    = 12,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [EW-1:0] wr_entry_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [EW-1:0] rd_entry_o
);
  logic [EW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g)) mem[g] <= wr_entry_i;
    end
  end

  assign rd_entry_o = mem[rd_idx_i];
endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_frame_tx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TICK_DIV   = 12500,
  parameter int START_LOW  = 74,
  parameter int START_PER  = 90,
  parameter int ZERO_LOW   = 30,
  parameter int ONE_LOW    = 12,
  parameter int BIT_PER    = 48,
  parameter int ACK_SAMPLE = 21,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ENTRY_W-1:0] wr_entry_i,
  input  logic [CNT_W-1:0]   bit_count_i,
  input  logic [2:0]         retry_max_i,
  input  logic [1:0]         free_sel_i,
  input  logic [3:0]         free_short_i,
  input  logic [3:0]         free_mid_i,
  input  logic [3:0]         free_long_i,
  input  logic               start_i,
  input  logic               line_i,
  output logic               drive_low_o,
  output logic               busy_o,
  output logic               done_ok_o,
  output logic               arb_lost_o,
  output logic               no_ack_o
);
  localparam int TCNT_W = $clog2(START_PER + 1);
  localparam int IDLE_W = $clog2(15 * BIT_PER + 1);

  logic tick, line_s;
  logic [ENTRY_W-1:0] cur_entry;
  tx_state_e state;
  logic [TCNT_W-1:0] tcnt;
  logic [IDLE_W-1:0] idle_cnt, idle_tgt;
  logic [CNT_W-1:0] bits_left, bit_total;
  logic [2:0] retries;
  logic in_start;
  logic [IDX_W-1:0] blk;
  logic [3:0] pos;
  logic ok_q, arb_q, nack_q;

  cec_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  cec_line_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .line_o(line_s)
  );

  cec_tx_buf #(.DEPTH(DEPTH), .EW(ENTRY_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_entry_i(wr_entry_i),
    .rd_idx_i(blk), .rd_entry_o(cur_entry)
  );

  function automatic logic [IDLE_W-1:0] free_ticks(input logic [3:0] n);
    return IDLE_W'(n) * IDLE_W'(BIT_PER);
  endfunction

  logic              cur_val, is_ack, bit_end, arb_hit, nack_hit, fail;
  logic [TCNT_W-1:0] low_len, per_m1;
  logic [3:0]        sel_n;

  always_comb begin
    cur_val = entry_bit(cur_entry, pos);
    is_ack  = (pos == 4'd9);
    if (in_start) begin
      low_len = TCNT_W'(START_LOW);
      per_m1  = TCNT_W'(START_PER - 1);
    end else begin
      low_len = cur_val ? TCNT_W'(ONE_LOW) : TCNT_W'(ZERO_LOW);
      per_m1  = TCNT_W'(BIT_PER - 1);
    end
    case (free_sel_i)
      2'd0:    sel_n = free_short_i;
      2'd1:    sel_n = free_mid_i;
      default: sel_n = free_long_i;
    endcase
    bit_end  = tick && (tcnt == per_m1);
    // a competing 0 pulls low after our logic-1 release, before a 0 would end
    arb_hit  = (state == ST_SEND) && tick && !in_start && !is_ack && cur_val &&
               (tcnt > TCNT_W'(ONE_LOW)) && (tcnt < TCNT_W'(ZERO_LOW)) && !line_s;
    nack_hit = (state == ST_SEND) && tick && !in_start && is_ack && cur_entry[0] &&
               (tcnt == TCNT_W'(ACK_SAMPLE)) && line_s;
    fail     = arb_hit || nack_hit;
  end

  assign drive_low_o = (state == ST_SEND) && (tcnt < low_len);
  assign busy_o      = (state != ST_IDLE);
  assign done_ok_o   = ok_q;
  assign arb_lost_o  = arb_q;
  assign no_ack_o    = nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      idle_cnt  <= '0;
      idle_tgt  <= '0;
      bits_left <= '0;
      bit_total <= '0;
      retries   <= '0;
      in_start  <= 1'b0;
      blk       <= '0;
      pos       <= '0;
      ok_q      <= 1'b0;
      arb_q     <= 1'b0;
      nack_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            bit_total <= (bit_count_i == '0) ? CNT_W'(1) : bit_count_i;
            retries   <= retry_max_i;
            idle_tgt  <= free_ticks(sel_n);
            idle_cnt  <= '0;
            ok_q      <= 1'b0;
            arb_q     <= 1'b0;
            nack_q    <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (!line_s) idle_cnt <= '0;
            else if (idle_cnt + 1'b1 >= idle_tgt) begin
              state     <= ST_SEND;
              tcnt      <= '0;
              in_start  <= 1'b1;
              blk       <= '0;
              pos       <= '0;
              bits_left <= bit_total;
            end else idle_cnt <= idle_cnt + 1'b1;
          end
        end
        ST_SEND: begin
          if (fail) begin
            if (retries != 3'd0) begin
              retries  <= retries - 3'd1;
              idle_tgt <= free_ticks(free_short_i);
              idle_cnt <= '0;
              state    <= ST_WAIT;
            end else begin
              arb_q  <= arb_hit;
              nack_q <= !arb_hit;
              state  <= ST_IDLE;
            end
          end else if (bit_end) begin
            tcnt <= '0;
            if (bits_left <= CNT_W'(1)) begin
              ok_q  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              bits_left <= bits_left - 1'b1;
              if (in_start) in_start <= 1'b0;
              else if (is_ack) begin
                pos <= '0;
                blk <= blk + 1'b1;
              end else pos <= pos + 4'd1;
            end
          end else if (tick) tcnt <= tcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cec_frame_tx_chk.sv
module cec_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic drive_low_o,
  input logic busy_o,
  input logic done_ok_o,
  input logic arb_lost_o,
  input logic no_ack_o
);
  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !drive_low_o);

  assert_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  assert_arb_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_lost_o) |-> !drive_low_o);

  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_ok_o, arb_lost_o, no_ack_o}));

  assert_result_on_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_ok_o || arb_lost_o || no_ack_o));

  assert_clear_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(done_ok_o || arb_lost_o || no_ack_o));
endmodule

bind cec_frame_tx cec_frame_tx_chk u_chk (.*);

// File: tb/tb_cec_frame_tx.sv
`timescale 1ns/1ps
module tb_cec_frame_tx;
  localparam int TD = 2;
  localparam int START_LOW = 74, START_PER = 90, ZERO_LOW = 30, ONE_LOW = 12;
  localparam int BIT_PER = 48;
  localparam int CYC_MAX = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [11:0] wr_entry = 0;
  logic [7:0]  bit_count = 0;
  logic [2:0]  retry_max = 0;
  logic [1:0]  free_sel = 0;
  logic        start = 0;
  logic        ext_low = 0;
  logic        drive_low, busy, ok, arb, nack;
  wire         line = ~(drive_low | ext_low);

  cec_frame_tx #(.TICK_DIV(TD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_entry_i(wr_entry), .bit_count_i(bit_count), .retry_max_i(retry_max),
    .free_sel_i(free_sel), .free_short_i(4'd3), .free_mid_i(4'd5),
    .free_long_i(4'd7), .start_i(start), .line_i(line),
    .drive_low_o(drive_low), .busy_o(busy), .done_ok_o(ok),
    .arb_lost_o(arb), .no_ack_o(nack)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int ext_wait = 0, ext_len = 0;
  int last_rise = -1, low_start = 0, first_rise = -1, exp_per = 0, gap = 0;
  int starts = 0, nbits = 0, wbad = 0, pbad = 0;
  int ack_mask = 0, arb_idx = -1;
  bit cur_start = 0, drv_prev = 0;
  int bits [0:255];
  logic [11:0] ents [0:15];

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int free_n(input int sel);
    return (sel == 0) ? 3 : (sel == 1) ? 5 : 7;
  endfunction

  // line monitor and follower model
  initial forever begin
    @(negedge clk);
    cyc++;
    if (ext_wait > 0) begin ext_wait--; ext_low = 0; end
    else if (ext_len > 0) begin ext_len--; ext_low = 1; end
    else ext_low = 0;
    if (drive_low && !drv_prev) begin
      int iv;
      iv = (last_rise < 0) ? 1000000 : cyc - last_rise;
      if (iv > 100 * TD) begin
        if (last_rise >= 0) gap = iv;
        cur_start = 1;
        starts++;
        nbits = 0;
        exp_per = START_PER * TD;
      end else begin
        if (iv != exp_per) pbad++;
        cur_start = 0;
        if (nbits % 10 == 9 && nbits / 10 < 31 && ack_mask[nbits / 10]) begin
          ext_wait = 0; ext_len = ZERO_LOW * TD;
        end
        if (nbits == arb_idx) begin
          ext_wait = (ONE_LOW + 3) * TD; ext_len = 8 * TD; arb_idx = -1;
        end
        exp_per = BIT_PER * TD;
      end
      if (first_rise < 0) first_rise = cyc;
      last_rise = cyc;
      low_start = cyc;
    end
    if (!drive_low && drv_prev) begin
      int w;
      w = cyc - low_start;
      if (cur_start) begin
        if (w != START_LOW * TD) wbad++;
      end else if (nbits < 256) begin
        if (w == ZERO_LOW * TD) bits[nbits++] = 0;
        else if (w == ONE_LOW * TD) bits[nbits++] = 1;
        else wbad++;
      end
    end
    drv_prev = drive_low;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=%0d exp=%0d", cyc, CYC_MAX);
    report();
    $finish;
  end

  task automatic run_frame(input int nblk, input int sel, input int rmax, input int amask,
                           input int arb_at, input int hold, input bit late,
                           input int exp_res, input int exp_att, input string tag);
    int res, lat, efree, mism;
    for (int b = 0; b < nblk; b++) begin
      @(negedge clk);
      wr_en = 1; wr_idx = 4'(b); wr_entry = ents[b];
    end
    @(negedge clk);
    wr_en = 0;
    bit_count = 8'(nblk * 10 + 1); retry_max = 3'(rmax); free_sel = 2'(sel);
    ack_mask = amask; arb_idx = arb_at;
    starts = 0; nbits = 0; wbad = 0; pbad = 0; first_rise = -1; gap = 0;
    @(negedge clk);
    start = 1;
    if (hold > 0) begin ext_wait = 0; ext_len = hold; end
    lat = cyc;
    @(negedge clk);
    start = 0;
    while (busy && cyc < CYC_MAX) begin
      @(negedge clk);
      if (late && cyc == lat + 1500) begin
        bit_count = 8'd1; free_sel = 2'd0; start = 1;
      end else start = 0;
    end
    start = 0;
    res = ok ? 1 : arb ? 2 : nack ? 3 : 0;
    chk(res == exp_res, {tag, " R10 result"}, res, exp_res);
    chk(starts == exp_att, {tag, " R9 attempts"}, starts, exp_att);
    chk(wbad == 0 && pbad == 0, {tag, " R4 R5 widths/periods"}, wbad + pbad, 0);
    chk(drive_low == 0, {tag, " R8 released after end"}, drive_low, 0);
    efree = hold + free_n(sel) * BIT_PER * TD;
    lat = first_rise - lat;
    chk(lat >= efree && lat <= efree + 2 * TD + 8, {tag, " R3 free time"}, lat, efree);
    if (exp_res == 1) begin
      mism = 0;
      for (int b = 0; b < nblk; b++) begin
        for (int k = 0; k < 10; k++) begin
          int e;
          e = (k < 8) ? int'(ents[b][11 - k]) : (k == 8) ? int'(ents[b][1]) : int'(ents[b][0]);
          if (bits[b * 10 + k] != e) mism++;
        end
      end
      chk(nbits == nblk * 10, {tag, " R6 bit count"}, nbits, nblk * 10);
      chk(mism == 0, {tag, " R6 R7 bit values"}, mism, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(drive_low == 0 && busy == 0, "R1 reset drive/busy", {drive_low, busy}, 0);
    chk({ok, arb, nack} == 3'b000, "R1 reset flags", {ok, arb, nack}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 idle after reset", busy, 0);

    // random frames, all acknowledged
    for (int f = 0; f < 6; f++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      for (int b = 0; b < nb; b++)
        ents[b] = {8'($urandom), 2'b00, (b == nb - 1), 1'b1};
      run_frame(nb, int'($urandom % 3), 3, 32'h7fff_ffff, -1, 0, 0, 1, 1, "rand R5 R6");
      repeat (20) @(negedge clk);
    end

    // no acknowledge on every attempt, two retries, repeats use short wait
    ents[0] = 12'h4F2 | 12'h001; ents[1] = 12'h363;
    run_frame(2, 2, 2, 0, -1, 0, 0, 3, 3, "nack R7 R9");
    chk(gap >= 3 * BIT_PER * TD && gap <= (ACK_SAMPLE_T() + 3 * BIT_PER + 3) * TD,
        "R9 repeat uses short free time", gap, 3 * BIT_PER * TD);

    // ack slot sent as logic 0, not sampled
    ents[0] = 12'hA52;
    run_frame(1, 0, 0, 0, -1, 0, 0, 1, 1, "ack0 R7");

    // lost arbitration, no retries
    ents[0] = 12'hFF3;
    run_frame(1, 0, 0, 1, 0, 0, 0, 2, 1, "arb R8");
    // lost arbitration then win on the repeat
    run_frame(1, 1, 1, 1, 0, 0, 0, 1, 2, "arb retry R9");

    // busy launch ignored
    ents[0] = 12'h5A1; ents[1] = 12'hC33;
    run_frame(2, 0, 0, 3, -1, 0, 1, 1, 1, "late start R2");

    // line held low at launch restarts the idle count
    ents[0] = 12'h0F3;
    run_frame(1, 1, 0, 1, -1, 400, 0, 1, 1, "hold R3");

    chk(busy == 0 && ok == 1, "R10 flag holds", {busy, ok}, 1);
    report();
    $finish;
  end

  function automatic int ACK_SAMPLE_T();
    return 21;
  endfunction
endmodule